// File: doc/BRIEF.md
# Cell and Auxiliary Threshold Alert Checker

This block watches a stream of 12-bit conversion results. Each result arrives with a channel code. Codes 0 to 5 are cell channels and codes 6 to 11 are auxiliary channels. The block compares each result against an 8-bit high limit and an 8-bit low limit, and each class has its own pair of limits. When a result crosses one of its class's limits, the block emits a single event. The event carries the class, the direction (rising or falling) and the channel code.

The four limits sit behind a small write-only register port. Software-side values arrive as signed numbers, and the block saturates them into the 8-bit range before storing them. At most one event comes out per sample, and the high-limit test always wins over the low-limit test. A limit change never splits a comparison: a word presented in the same cycle as a write is judged against the old limits.

Top module: `thr_alert_top`

## Requirements
- R1: While reset is active and after it is released, `evt_valid`, `evt_aux`, `evt_rise` and `evt_code` are all 0. The two high limits start at 0xFF and the two low limits start at 0x00.
- R2: Channel codes 0..5 are compared against the cell limit pair and raise events with `evt_aux`=0. Codes 6..11 are compared against the auxiliary pair and raise events with `evt_aux`=1. The limits of one class have no effect on the other class.
- R3: A sample whose value is greater than or equal to its class's high limit (zero-extended to 12 bits) raises a rising event, shown as `evt_rise`=1.
- R4: A sample below the high limit whose value is less than or equal to the low limit raises a falling event, shown as `evt_rise`=0. When both tests are true, only the rising event is raised.
- R5: A sample strictly between its class's low and high limits raises no event.
- R6: A sample with channel code 12..15 raises no event, whatever its value.
- R7: A write stores `wr_data` into the limit selected by `wr_sel`: 0 is the cell high limit, 1 the cell low limit, 2 the auxiliary high limit and 3 the auxiliary low limit. Each limit is 8 bits wide.
- R8: `wr_data` is a signed 16-bit number. Values below 0 are stored as 0x00, and values above 255 are stored as 0xFF.
- R9: An event is a `evt_valid` pulse one cycle wide. It appears in the cycle after the clock edge that accepts the sample, and `evt_code` carries that sample's channel code. No event appears without an accepted sample.
- R10: A sample accepted on the same edge as a limit write is compared against the old limit. The next sample uses the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A conversion sample is present this cycle |
| in_code | input | 4 | Channel code of the sample |
| in_value | input | 12 | Conversion result of the sample |
| wr_en | input | 1 | Limit write strobe |
| wr_sel | input | 2 | Limit selector (0 cell high, 1 cell low, 2 aux high, 3 aux low) |
| wr_data | input | 16 | Signed value to store, saturated to 0..255 |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_aux | output | 1 | Event class: 0 cell, 1 auxiliary |
| evt_rise | output | 1 | Event direction: 1 rising, 0 falling |
| evt_code | output | 4 | Channel code of the sample that raised the event |

## Verification
The default limits are tested with values just at and just inside them: 0xFF and 0xFE, and 0 and 1. These separate `>=` and `<=` from strict comparisons. A programmed window is probed at both edges and one step inside each edge, and also with a full-scale value that exceeds the 8-bit range. Crossed limits (low above high) show whether the rising test takes priority. Samples of both classes are sent with the same value but different limit pairs, which exposes any mixing of the pairs. Codes 12 to 15 are sent with full-scale values. Negative and oversized writes are each followed by a sample that only the saturated value would trip. A write and a sample in the same cycle show which limit the comparison used.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;

   // Number of programmable limits and the selector that addresses them.
   localparam int THR_COUNT = 4;
   localparam int THR_SEL_W = 2;

   // Selector encoding: even entries are high limits, odd entries low limits.
   typedef enum logic [THR_SEL_W-1:0] {
      SEL_CELL_HI = 2'd0,
      SEL_CELL_LO = 2'd1,
      SEL_AUX_HI  = 2'd2,
      SEL_AUX_LO  = 2'd3
   } thr_sel_e;

endpackage

// File: rtl/thr_clamp.sv
module thr_clamp #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 8
) (
   input  logic signed [IN_W-1:0] din,
   output logic        [OUT_W-1:0] dout
);

   localparam logic signed [IN_W-1:0] TOP_V = IN_W'((2 ** OUT_W) - 1);

   if (IN_W <= OUT_W) begin : g_bad_width
      $error("thr_clamp: IN_W must exceed OUT_W");
   end

   always_comb begin
      if (din < 0)
         dout = '0;
      else if (din > TOP_V)
         dout = '1;
      else
         dout = din[OUT_W-1:0];
   end

endmodule

// File: rtl/thr_regs.sv
module thr_regs
   import thr_alert_pkg::*;
#(
   parameter int THR_W = 8,
   parameter int WR_W  = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [THR_SEL_W-1:0]                 wr_sel,
   input  logic signed [WR_W-1:0]               wr_data,
   output logic [THR_COUNT-1:0][THR_W-1:0]      thr_q
);

   logic [THR_W-1:0] wr_sat;

   thr_clamp #(.IN_W(WR_W), .OUT_W(THR_W)) u_clamp (
      .din  (wr_data),
      .dout (wr_sat)
   );

   for (genvar g = 0; g < THR_COUNT; g++) begin : g_lim
      // High limits (even slots) reset to all ones, low limits to zero.
      localparam logic [THR_W-1:0] RST_V = (g % 2 == 0) ? '1 : '0;
      logic [THR_W-1:0] lim_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            lim_q <= RST_V;
         else if (wr_en && (wr_sel == THR_SEL_W'(g)))
            lim_q <= wr_sat;
      end

      assign thr_q[g] = lim_q;
   end

endmodule

// File: rtl/thr_cmp.sv
module thr_cmp
   import thr_alert_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int THR_W      = 8,
   parameter int CODE_W     = 4,
   parameter int CELL_CODES = 6,
   parameter int AUX_CODES  = 6
) (
   input  logic                             in_valid,
   input  logic [CODE_W-1:0]                in_code,
   input  logic [DATA_W-1:0]                in_value,
   input  logic [THR_COUNT-1:0][THR_W-1:0]  thr_q,
   output logic                             hit,
   output logic                             hit_aux,
   output logic                             hit_rise
);

   localparam logic [CODE_W:0] CELL_END = (CODE_W+1)'(CELL_CODES);
   localparam logic [CODE_W:0] AUX_END  = (CODE_W+1)'(CELL_CODES + AUX_CODES);

   logic              is_cell;
   logic              is_aux;
   logic [DATA_W-1:0] lim_hi;
   logic [DATA_W-1:0] lim_lo;
   logic              over;
   logic              under;

   assign is_cell = ({1'b0, in_code} < CELL_END);
   assign is_aux  = !is_cell && ({1'b0, in_code} < AUX_END);

   always_comb begin
      if (is_aux) begin
         lim_hi = DATA_W'(thr_q[SEL_AUX_HI]);
         lim_lo = DATA_W'(thr_q[SEL_AUX_LO]);
      end else begin
         lim_hi = DATA_W'(thr_q[SEL_CELL_HI]);
         lim_lo = DATA_W'(thr_q[SEL_CELL_LO]);
      end
   end

   // The high test decides first; the low test only counts when it fails.
   assign over     = (in_value >= lim_hi);
   assign under    = !over && (in_value <= lim_lo);
   assign hit      = in_valid && (is_cell || is_aux) && (over || under);
   assign hit_aux  = is_aux;
   assign hit_rise = over;

endmodule

// File: rtl/thr_alert_top.sv
module thr_alert_top
   import thr_alert_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int THR_W      = 8,
   parameter int CODE_W     = 4,
   parameter int WR_W       = 16,
   parameter int CELL_CODES = 6,
   parameter int AUX_CODES  = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [CODE_W-1:0]      in_code,
   input  logic [DATA_W-1:0]      in_value,
   input  logic                   wr_en,
   input  logic [THR_SEL_W-1:0]   wr_sel,
   input  logic signed [WR_W-1:0] wr_data,
   output logic                   evt_valid,
   output logic                   evt_aux,
   output logic                   evt_rise,
   output logic [CODE_W-1:0]      evt_code
);

   if (THR_W > DATA_W) begin : g_bad_thr
      $error("thr_alert_top: THR_W must not exceed DATA_W");
   end
   if (CELL_CODES + AUX_CODES > (2 ** CODE_W)) begin : g_bad_codes
      $error("thr_alert_top: channel codes do not fit CODE_W");
   end

   logic [THR_COUNT-1:0][THR_W-1:0] thr_q;
   logic                            hit;
   logic                            hit_aux;
   logic                            hit_rise;

   thr_regs #(.THR_W(THR_W), .WR_W(WR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .thr_q   (thr_q)
   );

   thr_cmp #(
      .DATA_W     (DATA_W),
      .THR_W      (THR_W),
      .CODE_W     (CODE_W),
      .CELL_CODES (CELL_CODES),
      .AUX_CODES  (AUX_CODES)
   ) u_cmp (
      .in_valid (in_valid),
      .in_code  (in_code),
      .in_value (in_value),
      .thr_q    (thr_q),
      .hit      (hit),
      .hit_aux  (hit_aux),
      .hit_rise (hit_rise)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_aux   <= 1'b0;
         evt_rise  <= 1'b0;
         evt_code  <= '0;
      end else begin
         evt_valid <= hit;
         if (hit) begin
            evt_aux  <= hit_aux;
            evt_rise <= hit_rise;
            evt_code <= in_code;
         end
      end
   end

endmodule

// File: rtl/thr_alert_chk.sv
module thr_alert_chk
   import thr_alert_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int THR_W      = 8,
   parameter int CODE_W     = 4,
   parameter int WR_W       = 16,
   parameter int CELL_CODES = 6,
   parameter int AUX_CODES  = 6
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            in_valid,
   input logic [CODE_W-1:0]               in_code,
   input logic [DATA_W-1:0]               in_value,
   input logic                            wr_en,
   input logic [THR_SEL_W-1:0]            wr_sel,
   input logic signed [WR_W-1:0]          wr_data,
   input logic                            evt_valid,
   input logic                            evt_aux,
   input logic                            evt_rise,
   input logic [CODE_W-1:0]               evt_code,
   input logic [THR_COUNT-1:0][THR_W-1:0] thr_q
);

   localparam int LAST_CODE = CELL_CODES + AUX_CODES;
   localparam logic signed [WR_W-1:0] SAT_V = WR_W'((2 ** THR_W) - 1);

   logic in_cell;
   logic in_bad;
   assign in_cell = (int'(in_code) < CELL_CODES);
   assign in_bad  = (int'(in_code) >= LAST_CODE);

   // R9
   evt_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> $past(in_valid));

   // R9
   evt_code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_code == $past(in_code)));

   // R2
   evt_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_aux == (int'($past(in_code)) >= CELL_CODES)));

   // R6
   bad_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_bad) |=> !evt_valid);

   // R3
   cell_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cell && (in_value >= DATA_W'(thr_q[SEL_CELL_HI])))
      |=> (evt_valid && evt_rise));

   // R5
   cell_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cell && (in_value > DATA_W'(thr_q[SEL_CELL_LO]))
       && (in_value < DATA_W'(thr_q[SEL_CELL_HI]))) |=> !evt_valid);

   // R8
   sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_CELL_HI) && (wr_data > SAT_V))
      |=> (thr_q[SEL_CELL_HI] == '1));

   // R8
   sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_AUX_LO) && (wr_data < 0))
      |=> (thr_q[SEL_AUX_LO] == '0));

endmodule

bind thr_alert_top thr_alert_chk #(
   .DATA_W     (DATA_W),
   .THR_W      (THR_W),
   .CODE_W     (CODE_W),
   .WR_W       (WR_W),
   .CELL_CODES (CELL_CODES),
   .AUX_CODES  (AUX_CODES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_code   (in_code),
   .in_value  (in_value),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .evt_valid (evt_valid),
   .evt_aux   (evt_aux),
   .evt_rise  (evt_rise),
   .evt_code  (evt_code),
   .thr_q     (thr_q)
);

// File: tb/sim_thr_alert_top.sv
`timescale 1ns/1ps
module sim_thr_alert_top;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [3:0]         in_code = '0;
   logic [11:0]        in_value = '0;
   logic               wr_en = 1'b0;
   logic [1:0]         wr_sel = '0;
   logic signed [15:0] wr_data = '0;
   logic               evt_valid;
   logic               evt_aux;
   logic               evt_rise;
   logic [3:0]         evt_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   thr_alert_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_code   (in_code),
      .in_value  (in_value),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .evt_valid (evt_valid),
      .evt_aux   (evt_aux),
      .evt_rise  (evt_rise),
      .evt_code  (evt_code)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Present one sample and check the event in the following cycle.
   task automatic sample(input logic [3:0] c, input logic [11:0] v,
                         input bit ev, input bit er, input bit ea, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_code = c; in_value = v;
      @(posedge clk); #1;
      check(req, "evt_valid", evt_valid, ev);
      if (ev) begin
         check(req, "evt_rise", evt_rise, er);
         check(req, "evt_aux", evt_aux, ea);
         check(req, "evt_code", evt_code, c);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic write_lim(input logic [1:0] s, input logic signed [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "evt_valid in reset", evt_valid, 0);
      check("R1", "evt_code in reset", evt_code, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "evt_valid after reset", evt_valid, 0);
      check("R1", "evt_rise after reset", evt_rise, 0);
   endtask

   task automatic t_defaults;
      // R1: high limit 0xFF, low limit 0 for both classes
      sample(4'd0, 12'h0FF, 1, 1, 0, "R1");
      sample(4'd0, 12'h0FE, 0, 0, 0, "R1");
      sample(4'd9, 12'h000, 1, 0, 1, "R1");
      sample(4'd9, 12'h001, 0, 0, 0, "R1");
   endtask

   task automatic t_cell_window;
      write_lim(2'd0, 16'sd100);
      write_lim(2'd1, 16'sd50);
      sample(4'd3, 12'd100, 1, 1, 0, "R3");
      sample(4'd3, 12'd4095, 1, 1, 0, "R3");
      sample(4'd3, 12'd99, 0, 0, 0, "R5");
      sample(4'd3, 12'd51, 0, 0, 0, "R5");
      sample(4'd5, 12'd50, 1, 0, 0, "R4");
      sample(4'd5, 12'd0, 1, 0, 0, "R4");
   endtask

   task automatic t_priority;
      write_lim(2'd0, 16'sd20);
      write_lim(2'd1, 16'sd40);
      sample(4'd1, 12'd30, 1, 1, 0, "R4");
      sample(4'd1, 12'd10, 1, 0, 0, "R4");
   endtask

   task automatic t_aux_split;
      write_lim(2'd2, 16'sd200);
      write_lim(2'd3, 16'sd10);
      // R2: same value judged by each class's own pair
      sample(4'd7, 12'd150, 0, 0, 1, "R2");
      sample(4'd2, 12'd150, 1, 1, 0, "R2");
      sample(4'd11, 12'd10, 1, 0, 1, "R2");
      sample(4'd6, 12'd200, 1, 1, 1, "R7");
   endtask

   task automatic t_bad_codes;
      for (int c = 12; c < 16; c++)
         sample(4'(c), 12'd4095, 0, 0, 0, "R6");
      sample(4'd12, 12'd0, 0, 0, 0, "R6");
   endtask

   task automatic t_saturate;
      write_lim(2'd3, -16'sd5);
      sample(4'd6, 12'd0, 1, 0, 1, "R8");
      sample(4'd6, 12'd1, 0, 0, 0, "R8");
      write_lim(2'd2, 16'sd1000);
      sample(4'd8, 12'd254, 0, 0, 0, "R8");
      sample(4'd8, 12'd255, 1, 1, 1, "R8");
   endtask

   task automatic t_same_cycle;
      // cell high is 20; write 90 while a sample of 50 arrives
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'sd90;
      in_valid = 1'b1; in_code = 4'd4; in_value = 12'd50;
      @(posedge clk); #1;
      check("R10", "old limit used", evt_valid, 1);
      check("R10", "old limit rise", evt_rise, 1);
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0;
      sample(4'd4, 12'd50, 0, 0, 0, "R10");
   endtask

   task automatic t_pulse;
      @(negedge clk);
      in_valid = 1'b1; in_code = 4'd2; in_value = 12'd4095;
      @(posedge clk); #1;
      check("R9", "pulse high", evt_valid, 1);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R9", "pulse one cycle", evt_valid, 0);
      check("R9", "code held", evt_code, 2);
   endtask

   initial begin
      t_reset();
      t_defaults();
      t_cell_window();
      t_priority();
      t_aux_split();
      t_bad_codes();
      t_saturate();
      t_same_cycle();
      t_pulse();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule